// File: doc/BRIEF.md
# Memory chip-select address decoder

This block watches memory cycles issued by a bus master and decides, one clock later, whether main memory should claim each cycle. The answer is a single registered chip-select flag. The decision combines a global enable, a programmable top-of-memory limit, two legacy low-memory windows with separate read and write enables, and an exclusion hole. The hole is set by a bottom and a top register at 64 KByte granularity and can only sit below 16 MByte.

Four 8-bit registers sit behind a small write and read port: control, hole bottom, hole top and top of memory. Software programs them once. The decoder then classifies every valid cycle from its 32-bit address and its direction.

The base region runs from address 0 up to 07FFFFh, plus everything from 1 MByte up to the programmed top of memory. The 512 KByte to 1 MByte area is claimed only through the two legacy windows. The video and option area 0A0000h–0EFFFFh is never claimed.

Top module: `mcs_decoder`

## Requirements
- R1: After reset the registers read back as control 00h (address 0), hole bottom 10h (address 1), hole top 0Fh (address 2) and top of memory 00h (address 3).
- R2: A register write on one clock edge is visible on the read port and in decoding from the next cycle on. Control bits 7:5 are reserved: they always read 0, whatever was written.
- R3: While control bit 4 (master enable) is 0, mem_cs is never asserted, whatever the address.
- R4: mem_cs is registered. It reflects the decision for the cycle presented with cyc_valid high in the previous clock, and it is 0 in the clock after a cycle with cyc_valid low.
- R5: Two address ranges are claimed without any window enable. The first is 000000h–07FFFFh. The second is 100000h and above, for addresses whose bits 31:20 are not above the top-of-memory register (1 MByte units).
- R6: The range 080000h–09FFFFh is claimed for writes only when control bit 1 is set, and for reads only when control bit 0 is set.
- R7: The range 0F0000h–0FFFFFh is claimed for writes only when control bit 3 is set, and for reads only when control bit 2 is set.
- R8: Addresses 0A0000h–0EFFFFh are never claimed.
- R9: An address lies in the hole when its bits 23:16 are at least the hole bottom and at most the hole top, both bounds inclusive. mem_cs is suppressed for any address in the hole.
- R10: When hole top is below hole bottom there is no hole. When the two are equal, the hole is exactly one 64 KByte block.
- R11: An address whose bits 31:24 are not all zero is never in the hole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | A bus-master memory cycle is presented this clock |
| cyc_addr | input | 32 | Byte address of the cycle |
| cyc_write | input | 1 | 1 for a memory write, 0 for a memory read |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 hole bottom, 2 hole top, 3 top of memory |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| mem_cs | output | 1 | Registered main-memory chip-select |

## Verification
The hardest situation to reach from the ports is an address that would be claimed except that it falls exactly on an edge of the hole. Reaching it takes a programmed top of memory, the master enable set, and hole bounds placed so that the bottom block, the top block and the blocks just outside them can each be probed. The stimulus programs the bounds through the register port and then walks addresses at the first and last byte of each 64 KByte block around both bounds. It repeats the walk with equal bounds and with inverted bounds, and once more with the same low 24 bits above 16 MByte. This shows that the inclusive comparison, the single-block case, the disabled case and the upper-byte qualifier each act on their own.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int ADDR_W = 32;
  localparam int REG_W  = 8;
  localparam int RSEL_W = 2;
  localparam int HOLE_LO = 16;
  localparam int HOLE_HI = HOLE_LO + REG_W - 1;   // 23
  localparam int TOM_LO  = 20;
  localparam int NUM_WIN = 2;
  localparam int CTRL_W  = 5;
  localparam int MEN_BIT = 4;

  typedef enum logic [RSEL_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_HBOT = 2'd1,
    SEL_HTOP = 2'd2,
    SEL_TOM  = 2'd3
  } reg_sel_e;

  localparam logic [REG_W-1:0] RST_CTRL = 8'h00;
  localparam logic [REG_W-1:0] RST_HBOT = 8'h10;
  localparam logic [REG_W-1:0] RST_HTOP = 8'h0F;
  localparam logic [REG_W-1:0] RST_TOM  = 8'h00;

  // legacy window bounds (inclusive) and the control bits that enable them
  localparam logic [ADDR_W-1:0] WIN_LO [NUM_WIN] = '{32'h0008_0000, 32'h000F_0000};
  localparam logic [ADDR_W-1:0] WIN_HI [NUM_WIN] = '{32'h0009_FFFF, 32'h000F_FFFF};
  localparam int WIN_RD_BIT [NUM_WIN] = '{0, 2};
  localparam int WIN_WR_BIT [NUM_WIN] = '{1, 3};

  localparam logic [ADDR_W-1:0] LOW_END = 32'h0008_0000;  // base region below this
  localparam logic [ADDR_W-1:0] ONE_MB  = 32'h0010_0000;

  function automatic logic f_in_hole(input logic [ADDR_W-1:0] a,
                                     input logic [REG_W-1:0] bot,
                                     input logic [REG_W-1:0] top);
    logic [REG_W-1:0] blk;
    blk = a[HOLE_HI:HOLE_LO];
    return (a[ADDR_W-1:HOLE_HI+1] == '0) && (blk >= bot) && (blk <= top);
  endfunction

  function automatic logic f_in_base(input logic [ADDR_W-1:0] a,
                                     input logic [REG_W-1:0] tom);
    logic [ADDR_W-TOM_LO-1:0] mb;
    mb = a[ADDR_W-1:TOM_LO];
    return (a < LOW_END) ||
           ((a >= ONE_MB) && (mb <= {{(ADDR_W-TOM_LO-REG_W){1'b0}}, tom}));
  endfunction

  function automatic logic f_in_window(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] lo,
                                       input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction
endpackage

// File: rtl/mcs_regs.sv
module mcs_regs
  import mcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RSEL_W-1:0] sel,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [CTRL_W-1:0] ctrl,
  output logic [REG_W-1:0]  hbot,
  output logic [REG_W-1:0]  htop,
  output logic [REG_W-1:0]  tom
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= RST_CTRL[CTRL_W-1:0];
      hbot <= RST_HBOT;
      htop <= RST_HTOP;
      tom  <= RST_TOM;
    end else if (we) begin
      unique case (reg_sel_e'(sel))
        SEL_CTRL: ctrl <= wdata[CTRL_W-1:0];
        SEL_HBOT: hbot <= wdata;
        SEL_HTOP: htop <= wdata;
        SEL_TOM:  tom  <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    unique case (reg_sel_e'(sel))
      SEL_CTRL: rdata = {{(REG_W-CTRL_W){1'b0}}, ctrl};
      SEL_HBOT: rdata = hbot;
      SEL_HTOP: rdata = htop;
      SEL_TOM:  rdata = tom;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/mcs_match.sv
module mcs_match
  import mcs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [REG_W-1:0]  hbot,
  input  logic [REG_W-1:0]  htop,
  input  logic [REG_W-1:0]  tom,
  output logic              in_hole,
  output logic              in_base,
  output logic              in_legacy
);
  logic [NUM_WIN-1:0] win_hit;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic dir_en;
    assign dir_en     = wr ? ctrl[WIN_WR_BIT[w]] : ctrl[WIN_RD_BIT[w]];
    assign win_hit[w] = dir_en && f_in_window(addr, WIN_LO[w], WIN_HI[w]);
  end

  assign in_legacy = |win_hit;
  assign in_hole   = f_in_hole(addr, hbot, htop);
  assign in_base   = f_in_base(addr, tom);
endmodule

// File: rtl/mcs_decoder.sv
module mcs_decoder
  import mcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_valid,
  input  logic [31:0]       cyc_addr,
  input  logic              cyc_write,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              mem_cs
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [REG_W-1:0]  hbot_q, htop_q, tom_q;
  logic              in_hole, in_base, in_legacy;
  logic              master_en, claim_hit;

  mcs_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .sel   (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .ctrl  (ctrl_q),
    .hbot  (hbot_q),
    .htop  (htop_q),
    .tom   (tom_q)
  );

  mcs_match u_match (
    .addr      (cyc_addr),
    .wr        (cyc_write),
    .ctrl      (ctrl_q),
    .hbot      (hbot_q),
    .htop      (htop_q),
    .tom       (tom_q),
    .in_hole   (in_hole),
    .in_base   (in_base),
    .in_legacy (in_legacy)
  );

  assign master_en = ctrl_q[MEN_BIT];
  assign claim_hit = master_en && !in_hole && (in_base || in_legacy);

  always_ff @(posedge clk) begin
    if (!rst_n) mem_cs <= 1'b0;
    else        mem_cs <= cyc_valid && claim_hit;
  end
endmodule

// File: rtl/mcs_decoder_chk.sv
module mcs_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cyc_valid,
  input logic [31:0] cyc_addr,
  input logic        mem_cs,
  input logic [7:0]  reg_rdata,
  input logic [1:0]  reg_addr,
  input logic        master_en,
  input logic        in_hole
);
  logic in_gap;
  assign in_gap = (cyc_addr >= 32'h000A_0000) && (cyc_addr <= 32'h000E_FFFF);

  assert_master_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs |-> $past(master_en));

  assert_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |=> !mem_cs);

  assert_hole_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && in_hole) |=> !mem_cs);

  assert_hole_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_hole |-> (cyc_addr[31:24] == 8'h00));

  assert_gap_never_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && in_gap) |=> !mem_cs);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[7:5] == 3'b000));
endmodule

bind mcs_decoder mcs_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_valid (cyc_valid),
  .cyc_addr  (cyc_addr),
  .mem_cs    (mem_cs),
  .reg_rdata (reg_rdata),
  .reg_addr  (reg_addr),
  .master_en (master_en),
  .in_hole   (in_hole)
);

// File: tb/mcs_decoder_tb_top.sv
module mcs_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_valid = 1'b0;
  logic [31:0] cyc_addr = '0;
  logic        cyc_write = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        mem_cs;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  // bench-side shadow of the programmed values
  logic [7:0] m_ctrl = 8'h00, m_bot = 8'h10, m_top = 8'h0F, m_tom = 8'h00;

  always #2 clk = ~clk;  // 250 MHz

  mcs_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_addr(cyc_addr),
    .cyc_write(cyc_write), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_cs(mem_cs)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // requirement model, restated with 64K block numbers
  function automatic bit model_cs(input logic [31:0] a, input bit wr);
    int unsigned blk = a >> 16;          // 64K block index
    bit hole, base, leg;
    if (!m_ctrl[4]) return 0;
    hole = (blk < 256) && (blk >= m_bot) && (blk <= m_top);
    base = (blk < 8) || ((blk >= 16) && ((blk >> 4) <= m_tom));
    leg  = ((blk == 8 || blk == 9) && (wr ? m_ctrl[1] : m_ctrl[0])) ||
           ((blk == 15) && (wr ? m_ctrl[3] : m_ctrl[2]));
    return !hole && (base || leg);
  endfunction

  task automatic wr_reg(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    case (sel)
      2'd0: m_ctrl = d & 8'h1F;
      2'd1: m_bot = d;
      2'd2: m_top = d;
      default: m_tom = d;
    endcase
  endtask

  task automatic rd_chk(input string req, input logic [1:0] sel, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = sel;
    #1 check(req, {24'h0, reg_rdata}, {24'h0, exp});
  endtask

  task automatic cyc(input string req, input logic [31:0] a, input bit wr);
    @(negedge clk);
    cyc_valid = 1; cyc_addr = a; cyc_write = wr;
    @(negedge clk);
    cyc_valid = 0;
    check(req, {31'h0, mem_cs}, {31'h0, model_cs(a, wr)});
  endtask

  task automatic cyc_exp(input string req, input logic [31:0] a, input bit wr, input bit exp);
    @(negedge clk);
    cyc_valid = 1; cyc_addr = a; cyc_write = wr;
    @(negedge clk);
    cyc_valid = 0;
    check(req, {31'h0, mem_cs}, {31'h0, exp});
  endtask

  task automatic t_reset;
    check("R4 reset", {31'h0, mem_cs}, 32'h0);
    rd_chk("R1 ctrl", 2'd0, 8'h00);
    rd_chk("R1 hbot", 2'd1, 8'h10);
    rd_chk("R1 htop", 2'd2, 8'h0F);
    rd_chk("R1 tom",  2'd3, 8'h00);
  endtask

  task automatic t_regs;
    wr_reg(2'd0, 8'hFF);
    rd_chk("R2 ctrl reserved", 2'd0, 8'h1F);
    wr_reg(2'd3, 8'h3C);
    rd_chk("R2 tom", 2'd3, 8'h3C);
  endtask

  task automatic t_enable;
    wr_reg(2'd0, 8'h0F);
    cyc_exp("R3 off low", 32'h0000_1000, 0, 0);
    cyc_exp("R3 off high", 32'h0200_0000, 1, 0);
    wr_reg(2'd0, 8'h1F);
    cyc_exp("R3 on", 32'h0000_1000, 0, 1);
  endtask

  task automatic t_timing;
    cyc_exp("R4 hit", 32'h0000_0040, 1, 1);
    @(negedge clk);
    check("R4 idle after hit", {31'h0, mem_cs}, 32'h0);
  endtask

  task automatic t_base;
    wr_reg(2'd0, 8'h10);
    wr_reg(2'd3, 8'h05);
    cyc_exp("R5 07FFFF", 32'h0007_FFFF, 0, 1);
    cyc_exp("R5 1MB", 32'h0010_0000, 1, 1);
    cyc_exp("R5 top MB", 32'h005F_FFFF, 0, 1);
    cyc_exp("R5 above tom", 32'h0060_0000, 0, 0);
    cyc("R5 model", 32'h0023_4567, 1);
  endtask

  task automatic t_legacy;
    for (int m = 0; m < 16; m++) begin
      wr_reg(2'd0, 8'h10 | 8'(m));
      cyc("R6 rd", 32'h0008_0000, 0);
      cyc("R6 wr", 32'h0009_FFFF, 1);
      cyc("R7 rd", 32'h000F_0000, 0);
      cyc("R7 wr", 32'h000F_FFFF, 1);
    end
    wr_reg(2'd0, 8'h11);
    cyc_exp("R6 rd only", 32'h0009_0000, 1, 0);
    wr_reg(2'd0, 8'h18);
    cyc_exp("R7 wr only", 32'h000F_8000, 1, 1);
  endtask

  task automatic t_gap;
    wr_reg(2'd0, 8'h1F);
    cyc_exp("R8 A0000", 32'h000A_0000, 0, 0);
    cyc_exp("R8 EFFFF", 32'h000E_FFFF, 1, 0);
    cyc_exp("R8 C8000", 32'h000C_8000, 0, 0);
  endtask

  task automatic t_hole;
    wr_reg(2'd3, 8'hFF);
    wr_reg(2'd1, 8'h21);
    wr_reg(2'd2, 8'h24);
    cyc_exp("R9 below", 32'h0020_FFFF, 0, 1);
    cyc_exp("R9 bottom", 32'h0021_0000, 0, 0);
    cyc_exp("R9 top", 32'h0024_FFFF, 1, 0);
    cyc_exp("R9 above", 32'h0025_0000, 1, 1);
    wr_reg(2'd2, 8'h21);
    cyc_exp("R10 equal in", 32'h0021_8000, 0, 0);
    cyc_exp("R10 equal next", 32'h0022_0000, 0, 1);
    cyc_exp("R10 equal prev", 32'h0020_FFFF, 0, 1);
    wr_reg(2'd2, 8'h20);
    cyc_exp("R10 inverted", 32'h0021_0000, 0, 1);
    cyc_exp("R10 inverted b", 32'h0020_0000, 0, 1);
  endtask

  task automatic t_high;
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd2, 8'hFF);
    cyc_exp("R11 low in hole", 32'h0030_0000, 0, 0);
    cyc_exp("R11 above 16MB", 32'h0130_0000, 0, 1);
    cyc_exp("R11 far", 32'h0F00_0000, 1, 1);
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_regs;
    t_enable;
    t_timing;
    t_base;
    t_legacy;
    t_gap;
    t_hole;
    t_high;
    repeat (2) @(negedge clk);
    done = 1;
    summary;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary;
    end
  end
endmodule